// File: doc/BRIEF.md
# Backplane Receive Serializer (Clock Slave)

This block puts one link's received frame onto a serial backplane. The backplane supplies the bit clock and the frame pulse. A frame holds 32 timeslots of 8 bits each, which is 256 bit periods per frame. For every bit period the block gives a timeslot index to a frame buffer. It then shifts the returned data byte out on a serial data pin, MSB first. On a second pin it sends the timeslot's signaling nibble, so that both pins carry the same timeslot at the same time. Each pin has its own output enable, so the line can be put into high impedance.

A faster internal clock oversamples the backplane clock and turns it into rise and fall strobes. Configuration inputs choose:
- which edge samples the frame pulse;
- which edge launches the outputs;
- whether the backplane clock runs at 1x or 2x the bit rate, and at 2x which half of the bit launches;
- the frame pulse polarity;
- a timeslot and bit offset between the frame pulse and the start of the output frame.

The frame pulse may recur at any whole number of frames. A pulse at any other spacing sets a sticky error flag, and the flag can raise an interrupt.

Top module: `bp_rx_ser`

## Requirements
- R1: The frame pulse is sampled only on the backplane clock edge chosen by `cfg_fp_fall` (0 = rising, 1 = falling). At 2x rate it is sampled only on the first such edge of each bit period. That edge is aligned to the pulse itself while the block is not yet locked.
- R2: Outputs change only on the edge chosen by `cfg_dat_fall` (0 = rising, 1 = falling). When the launch edge differs from the sampling edge, it launches the bit of the period that the last sampling edge opened.
- R3: With `cfg_rate_2x` = 1, the backplane clock has two edges of each kind per bit, and exactly one launch occurs per bit. `cfg_late_half` = 0 picks the first launch-type edge of the bit and 1 picks the second.
- R4: `cfg_fp_low` = 0 treats a high frame pulse as active, and 1 treats a low one as active.
- R5: The bit period in which an active pulse is sampled has position 0. The bit launched at position p is frame bit k = (p − (8·`cfg_ts_ofs` + `cfg_bit_ofs`)) mod 256. `rd_ts` = k[7:3], and `ser_data` = `rd_data`[7 − k[2:0]], so data goes out MSB first.
- R6: `ser_sig` carries the signaling of the same timeslot as `ser_data`. It is 1 for bit indices 0 to 3 of the timeslot. For indices 4 to 7 it is `rd_sig`[7 − index], so the nibble goes out MSB first.
- R7: After reset, and until the first active frame pulse is sampled, `ser_data` and `ser_sig` are 1.
- R8: `err_flag` is set when an active pulse is sampled while locked and the spacing since the previous pulse is not a multiple of 256 bit periods. The flag holds until `err_clear` is high for a cycle with no new error in the same cycle. A new error takes priority over a clear. After an error the frame restarts at the new pulse.
- R9: `irq` is high exactly when `err_flag` and `cfg_irq_en` are both high.
- R10: `ser_data_oe` and `ser_sig_oe` are 0 when `cfg_hiz` = 1 and 1 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oversampling clock |
| rst_n | input | 1 | Active-low reset |
| bp_clk | input | 1 | Backplane bit clock (asynchronous) |
| bp_fp | input | 1 | Backplane frame pulse |
| cfg_fp_fall | input | 1 | Frame pulse sampling edge: 1 = falling |
| cfg_dat_fall | input | 1 | Output launch edge: 1 = falling |
| cfg_rate_2x | input | 1 | Backplane clock at twice the bit rate |
| cfg_late_half | input | 1 | At 2x, launch on the second edge of the bit |
| cfg_fp_low | input | 1 | Frame pulse active low |
| cfg_ts_ofs | input | 5 | Timeslot offset, 0 to 31 |
| cfg_bit_ofs | input | 3 | Bit offset within a timeslot |
| cfg_hiz | input | 1 | Put both outputs into high impedance |
| cfg_irq_en | input | 1 | Interrupt enable |
| err_clear | input | 1 | Write-one clear of the error flag |
| rd_ts | output | 5 | Timeslot index read from the frame buffer |
| rd_data | input | 8 | Data byte for `rd_ts` |
| rd_sig | input | 4 | Signaling nibble for `rd_ts` |
| ser_data | output | 1 | Serial data |
| ser_data_oe | output | 1 | Output enable for serial data |
| ser_sig | output | 1 | Serial signaling |
| ser_sig_oe | output | 1 | Output enable for serial signaling |
| err_flag | output | 1 | Sticky frame pulse spacing error |
| irq | output | 1 | Interrupt |

## Verification
If the bit counter or the frame reference is wrong, the serial stream shows it within one bit period of the next launch. It appears as a byte fetched for the wrong timeslot, a rotated bit order, or a signaling nibble out of step with its data. If the 2x phase tracker is wrong, the launch lands on the wrong half of the bit. It can also launch twice per bit and slip the stream by a position. A faulty spacing check only shows when a pulse arrives: a legal two-frame spacing then raises `err_flag`, or an odd spacing leaves it low. Either shows a few internal cycles after the sampling edge.

// File: rtl/bp_rx_pkg.sv
package bp_rx_pkg;
   typedef struct packed {
      logic rise;
      logic fall;
   } strobe_t;

   function automatic logic pick_edge(input strobe_t s, input logic use_fall);
      return use_fall ? s.fall : s.rise;
   endfunction
endpackage

// File: rtl/bp_edge_sync.sv
module bp_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bp_clk,
   input  logic                bp_fp,
   output bp_rx_pkg::strobe_t  stb,
   output logic                fp_lvl
);
   localparam int MSB = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("bp_edge_sync: STAGES must be at least 2");
   end

   logic [MSB:0]    clk_sh;
   logic [MSB:0]    fp_sh;
   logic            clk_prev;
   logic [STAGES:0] prime_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_sh   <= '0;
         fp_sh    <= '0;
         clk_prev <= 1'b0;
         prime_sh <= '0;
      end else begin
         clk_sh   <= {clk_sh[MSB-1:0], bp_clk};
         fp_sh    <= {fp_sh[MSB-1:0], bp_fp};
         clk_prev <= clk_sh[MSB];
         prime_sh <= {prime_sh[STAGES-1:0], 1'b1};
      end
   end

   always_comb begin
      stb.rise = prime_sh[STAGES] &  clk_sh[MSB] & ~clk_prev;
      stb.fall = prime_sh[STAGES] & ~clk_sh[MSB] &  clk_prev;
   end
   assign fp_lvl = fp_sh[MSB];
endmodule

// File: rtl/bp_frame_timer.sv
module bp_frame_timer #(
   parameter int FRAME_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fp_stb,
   input  logic               fp_act,
   input  logic               rate_2x,
   input  logic               err_clear,
   output logic               tick,
   output logic [FRAME_W-1:0] cur_pos,
   output logic [FRAME_W-1:0] pos_q,
   output logic               fp_ph,
   output logic               locked,
   output logic               locked_now,
   output logic               err_set,
   output logic               err_flag
);
   logic [FRAME_W-1:0] bitcnt;
   logic               first_edge;
   logic               pulse_tick;

   always_comb begin
      first_edge = ~rate_2x | ~fp_ph | (~locked & fp_act);
      tick       = fp_stb & first_edge;
      pulse_tick = tick & fp_act;
      cur_pos    = pulse_tick ? '0 : bitcnt;
      err_set    = pulse_tick & locked & (bitcnt != '0);
      locked_now = locked | pulse_tick;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bitcnt   <= '0;
         pos_q    <= '0;
         fp_ph    <= 1'b0;
         locked   <= 1'b0;
         err_flag <= 1'b0;
      end else begin
         if (tick) begin
            bitcnt <= cur_pos + 1'b1;
            pos_q  <= cur_pos;
         end
         if (fp_stb) fp_ph <= rate_2x & first_edge;
         if (pulse_tick) locked <= 1'b1;
         err_flag <= err_set | (err_flag & ~err_clear);
      end
   end
endmodule

// File: rtl/bp_bit_serializer.sv
module bp_bit_serializer #(
   parameter int TS_W   = 5,
   parameter int BIT_W  = 3,
   parameter int SIG_W  = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   dat_stb,
   input  logic                   same_edge,
   input  logic                   rate_2x,
   input  logic                   late_half,
   input  logic                   tick,
   input  logic                   fp_ph,
   input  logic                   locked_now,
   input  logic [TS_W+BIT_W-1:0]  cur_pos,
   input  logic [TS_W+BIT_W-1:0]  pos_q,
   input  logic [TS_W+BIT_W-1:0]  offset,
   output logic [TS_W-1:0]        rd_ts,
   input  logic [(1<<BIT_W)-1:0]  rd_data,
   input  logic [SIG_W-1:0]       rd_sig,
   output logic                   launch,
   output logic                   sd,
   output logic                   sg
);
   localparam int FRAME_W = TS_W + BIT_W;
   localparam int NBITS   = 1 << BIT_W;
   localparam int SIG_LO  = NBITS - SIG_W;

   if (SIG_W > NBITS || SIG_W < 1) begin : g_bad_sig
      $error("bp_bit_serializer: SIG_W must be 1..bits per timeslot");
   end

   logic [FRAME_W-1:0] pos_now;
   logic [FRAME_W-1:0] kbit;
   logic [BIT_W-1:0]   bidx;
   logic [BIT_W-1:0]   sel;
   logic               half_ok;
   logic               sig_bit;

   always_comb begin
      if (same_edge) half_ok = tick ? ~late_half : late_half;
      else           half_ok = fp_ph ^ late_half;
      launch  = dat_stb & (~rate_2x | half_ok);
      pos_now = tick ? cur_pos : pos_q;
      kbit    = pos_now - offset;
      bidx    = kbit[BIT_W-1:0];
      sel     = BIT_W'(NBITS - 1) - bidx;
      rd_ts   = kbit[FRAME_W-1:BIT_W];
   end

   if (SIG_W == NBITS) begin : g_sig_full
      assign sig_bit = rd_sig[sel];
   end else begin : g_sig_window
      logic [SIG_W-1:0] sig_ext;
      assign sig_ext = rd_sig;
      assign sig_bit = (int'(bidx) >= SIG_LO) ? sig_ext[sel[$clog2(SIG_W+1)-1:0]] : 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sd <= 1'b1;
         sg <= 1'b1;
      end else if (launch) begin
         sd <= locked_now ? rd_data[sel] : 1'b1;
         sg <= locked_now ? sig_bit : 1'b1;
      end
   end
endmodule

// File: rtl/bp_rx_ser.sv
module bp_rx_ser #(
   parameter int TS_PER_FRAME = 32,
   parameter int BITS_PER_TS  = 8,
   parameter int SIG_W        = 4,
   parameter int SYNC_STAGES  = 2,
   localparam int TS_W        = $clog2(TS_PER_FRAME),
   localparam int BIT_W       = $clog2(BITS_PER_TS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bp_clk,
   input  logic                   bp_fp,
   input  logic                   cfg_fp_fall,
   input  logic                   cfg_dat_fall,
   input  logic                   cfg_rate_2x,
   input  logic                   cfg_late_half,
   input  logic                   cfg_fp_low,
   input  logic [TS_W-1:0]        cfg_ts_ofs,
   input  logic [BIT_W-1:0]       cfg_bit_ofs,
   input  logic                   cfg_hiz,
   input  logic                   cfg_irq_en,
   input  logic                   err_clear,
   output logic [TS_W-1:0]        rd_ts,
   input  logic [BITS_PER_TS-1:0] rd_data,
   input  logic [SIG_W-1:0]       rd_sig,
   output logic                   ser_data,
   output logic                   ser_data_oe,
   output logic                   ser_sig,
   output logic                   ser_sig_oe,
   output logic                   err_flag,
   output logic                   irq
);
   import bp_rx_pkg::*;
   localparam int FRAME_W = TS_W + BIT_W;

   if ((1 << TS_W) != TS_PER_FRAME || (1 << BIT_W) != BITS_PER_TS) begin : g_bad_geom
      $error("bp_rx_ser: frame geometry must be powers of two");
   end

   strobe_t            stb;
   logic               fp_lvl;
   logic               fp_stb;
   logic               dat_stb;
   logic               fp_act;
   logic               tick;
   logic [FRAME_W-1:0] cur_pos;
   logic [FRAME_W-1:0] pos_q;
   logic               fp_ph;
   logic               locked;
   logic               locked_now;
   logic               err_set;
   logic               launch;

   bp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .bp_clk(bp_clk), .bp_fp(bp_fp),
      .stb(stb), .fp_lvl(fp_lvl)
   );

   assign fp_stb  = pick_edge(stb, cfg_fp_fall);
   assign dat_stb = pick_edge(stb, cfg_dat_fall);
   assign fp_act  = fp_lvl ^ cfg_fp_low;

   bp_frame_timer #(.FRAME_W(FRAME_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .fp_stb(fp_stb), .fp_act(fp_act),
      .rate_2x(cfg_rate_2x), .err_clear(err_clear), .tick(tick),
      .cur_pos(cur_pos), .pos_q(pos_q), .fp_ph(fp_ph), .locked(locked),
      .locked_now(locked_now), .err_set(err_set), .err_flag(err_flag)
   );

   bp_bit_serializer #(.TS_W(TS_W), .BIT_W(BIT_W), .SIG_W(SIG_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .dat_stb(dat_stb),
      .same_edge(cfg_fp_fall == cfg_dat_fall), .rate_2x(cfg_rate_2x),
      .late_half(cfg_late_half), .tick(tick), .fp_ph(fp_ph),
      .locked_now(locked_now), .cur_pos(cur_pos), .pos_q(pos_q),
      .offset({cfg_ts_ofs, cfg_bit_ofs}), .rd_ts(rd_ts), .rd_data(rd_data),
      .rd_sig(rd_sig), .launch(launch), .sd(ser_data), .sg(ser_sig)
   );

   assign ser_data_oe = ~cfg_hiz;
   assign ser_sig_oe  = ~cfg_hiz;
   assign irq         = err_flag & cfg_irq_en;
endmodule

// File: rtl/bp_rx_ser_chk.sv
module bp_rx_ser_chk (
   input logic clk,
   input logic rst_n,
   input logic locked,
   input logic ser_data,
   input logic ser_sig,
   input logic launch,
   input logic tick,
   input logic fp_stb,
   input logic err_set,
   input logic err_flag,
   input logic err_clear
);
   // R7: unlocked block drives idle ones on both pins
   a_r7_idle_ones: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |-> (ser_data && ser_sig));
   // R2: data pin moves only after a launch strobe
   a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !launch |=> $stable(ser_data) && $stable(ser_sig));
   // R1: bit ticks come only from the sampling edge
   a_r1_tick_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> fp_stb);
   // R8: detection sets the flag
   a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
      err_set |=> err_flag);
   // R8: flag is sticky without a clear
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag && !err_clear |=> err_flag);
endmodule

bind bp_rx_ser bp_rx_ser_chk u_chk (
   .clk(clk), .rst_n(rst_n), .locked(locked), .ser_data(ser_data),
   .ser_sig(ser_sig), .launch(launch), .tick(tick), .fp_stb(fp_stb),
   .err_set(err_set), .err_flag(err_flag), .err_clear(err_clear)
);

// File: tb/bp_rx_ser_bench.sv
module bp_rx_ser_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bp_clk = 1'b0;
   logic bp_fp = 1'b0;
   logic cfg_fp_fall = 1'b0, cfg_dat_fall = 1'b0, cfg_rate_2x = 1'b0;
   logic cfg_late_half = 1'b0, cfg_fp_low = 1'b0, cfg_hiz = 1'b0, cfg_irq_en = 1'b0;
   logic [4:0] cfg_ts_ofs = '0;
   logic [2:0] cfg_bit_ofs = '0;
   logic err_clear = 1'b0;
   logic [4:0] rd_ts;
   logic [7:0] rd_data;
   logic [3:0] rd_sig;
   logic ser_data, ser_data_oe, ser_sig, ser_sig_oe, err_flag, irq;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   function automatic logic [7:0] dval(input logic [4:0] t);
      return 8'((int'(t) * 37 + 11) & 255);
   endfunction
   function automatic logic [3:0] sval(input logic [4:0] t);
      return t[3:0] ^ 4'h5;
   endfunction

   assign rd_data = dval(rd_ts);
   assign rd_sig  = sval(rd_ts);

   bp_rx_ser u_bp_rx_ser (
      .clk(clk), .rst_n(rst_n), .bp_clk(bp_clk), .bp_fp(bp_fp),
      .cfg_fp_fall(cfg_fp_fall), .cfg_dat_fall(cfg_dat_fall),
      .cfg_rate_2x(cfg_rate_2x), .cfg_late_half(cfg_late_half),
      .cfg_fp_low(cfg_fp_low), .cfg_ts_ofs(cfg_ts_ofs), .cfg_bit_ofs(cfg_bit_ofs),
      .cfg_hiz(cfg_hiz), .cfg_irq_en(cfg_irq_en), .err_clear(err_clear),
      .rd_ts(rd_ts), .rd_data(rd_data), .rd_sig(rd_sig),
      .ser_data(ser_data), .ser_data_oe(ser_data_oe), .ser_sig(ser_sig),
      .ser_sig_oe(ser_sig_oe), .err_flag(err_flag), .irq(irq)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard
   logic [1:0] exp_q[$];
   string      tag_q[$];
   event       smp_ev;
   string      scen_tag = "";

   initial begin
      forever begin
         @(smp_ev);
         if (exp_q.size() == 0) begin
            check("R2 missing expectation", 8'd1, 8'd0);
         end else begin
            logic [1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({t, " data"}, {7'd0, ser_data}, {7'd0, e[1]});
            check({t, " sig"},  {7'd0, ser_sig},  {7'd0, e[0]});
         end
      end
   end

   int  q_pos = 0;
   bit  locked_m = 1'b0;

   // one bit period; pulse = frame pulse active in this bit
   task automatic do_bit(input bit pulse);
      int halves;
      int lidx;
      halves = cfg_rate_2x ? 4 : 2;
      lidx = (cfg_fp_fall == cfg_dat_fall ? 0 : 1) + (cfg_rate_2x ? 2 * int'(cfg_late_half) : 0);
      if (pulse) begin q_pos = 0; locked_m = 1'b1; end
      else q_pos = (q_pos + 1) & 255;
      @(negedge clk);
      bp_fp = pulse ^ cfg_fp_low;
      repeat (3) @(negedge clk);
      for (int h = 0; h < halves; h++) begin
         bp_clk = (~cfg_fp_fall) ^ h[0];
         if (h == lidx) begin
            logic ed, es;
            if (!locked_m) begin
               ed = 1'b1; es = 1'b1;
            end else begin
               int k, bi;
               logic [4:0] ts;
               k  = (q_pos - (int'(cfg_ts_ofs) * 8 + int'(cfg_bit_ofs))) & 255;
               ts = 5'(k >> 3);
               bi = k & 7;
               ed = dval(ts)[7 - bi];
               es = (bi >= 4) ? sval(ts)[7 - bi] : 1'b1;
            end
            exp_q.push_back({ed, es});
            tag_q.push_back(locked_m ? scen_tag : "R7");
            repeat (6) @(negedge clk);
            -> smp_ev;
            repeat (2) @(negedge clk);
         end else begin
            repeat (8) @(negedge clk);
         end
      end
   endtask

   task automatic setup(input bit fpf, input bit datf, input bit r2x, input bit late,
                        input bit low, input int tso, input int bo, input string tg);
      rst_n = 1'b0;
      cfg_fp_fall = fpf; cfg_dat_fall = datf; cfg_rate_2x = r2x;
      cfg_late_half = late; cfg_fp_low = low;
      cfg_ts_ofs = 5'(tso); cfg_bit_ofs = 3'(bo);
      bp_clk = fpf; bp_fp = low;
      scen_tag = tg;
      locked_m = 1'b0; q_pos = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R7 reset data", {7'd0, ser_data}, 8'd1);
      check("R7 reset sig",  {7'd0, ser_sig},  8'd1);
      check("R8 reset flag", {7'd0, err_flag}, 8'd0);
   endtask

   task automatic scen(input bit fpf, input bit datf, input bit r2x, input bit late,
                       input bit low, input int tso, input int bo, input string tg);
      setup(fpf, datf, r2x, late, low, tso, bo, tg);
      for (int i = 0; i < 10; i++) do_bit(1'b0);
      do_bit(1'b1);
      for (int i = 0; i < 255; i++) do_bit(1'b0);
      do_bit(1'b1);
      for (int i = 0; i < 40; i++) do_bit(1'b0);
      check("R8 aligned pulses no error", {7'd0, err_flag}, 8'd0);
   endtask

   initial begin
      // R1 R5 R6: rising sample, rising launch, no offset
      scen(0, 0, 0, 0, 0, 0, 0, "R1 R5 R6 1x");
      // R2 R5: launch on opposite edge, offset 3 timeslots + 5 bits
      scen(0, 1, 0, 0, 0, 3, 5, "R2 R5 1x-split");
      // R3 R4: 2x, falling sample, late half, active-low pulse, max offset
      scen(1, 0, 1, 1, 1, 31, 7, "R3 R4 R5 2x-late");
      // R3: 2x, same edges, early half
      scen(1, 1, 1, 0, 0, 9, 2, "R3 R6 2x-early");
      // R3: 2x, same edges, late half
      scen(0, 0, 1, 1, 0, 17, 0, "R3 R5 2x-same-late");

      // R8 R9 R10: spacing errors, interrupt, clear, tri-state
      setup(0, 0, 0, 0, 0, 2, 1, "R8 R5 resync");
      cfg_irq_en = 1'b1;
      for (int i = 0; i < 5; i++) do_bit(1'b0);
      do_bit(1'b1);
      for (int i = 0; i < 511; i++) do_bit(1'b0);
      do_bit(1'b1);
      repeat (4) @(negedge clk);
      check("R8 two-frame spacing accepted", {7'd0, err_flag}, 8'd0);
      check("R9 no irq without flag", {7'd0, irq}, 8'd0);
      for (int i = 0; i < 99; i++) do_bit(1'b0);
      do_bit(1'b1);
      for (int i = 0; i < 20; i++) do_bit(1'b0);
      check("R8 odd spacing sets flag", {7'd0, err_flag}, 8'd1);
      check("R9 irq with enable", {7'd0, irq}, 8'd1);
      @(negedge clk); cfg_irq_en = 1'b0;
      @(negedge clk);
      check("R9 irq masked", {7'd0, irq}, 8'd0);
      check("R8 flag sticky", {7'd0, err_flag}, 8'd1);
      err_clear = 1'b1;
      @(negedge clk); err_clear = 1'b0;
      @(negedge clk);
      check("R8 flag cleared", {7'd0, err_flag}, 8'd0);
      cfg_hiz = 1'b1;
      @(negedge clk);
      check("R10 data hiz", {7'd0, ser_data_oe}, 8'd0);
      check("R10 sig hiz",  {7'd0, ser_sig_oe},  8'd0);
      cfg_hiz = 1'b0;
      @(negedge clk);
      check("R10 data driven", {7'd0, ser_data_oe}, 8'd1);
      check("R10 sig driven",  {7'd0, ser_sig_oe},  8'd1);
      check("R5 scoreboard drained", 8'(exp_q.size()), 8'd0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog R1 actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule